// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a synthesizable model of a clocked static RAM. Each word is 18 bits, split into two 9-bit byte lanes, and the depth is set by a parameter. A rising clock edge captures the address, the write data, the chip enable, both byte-lane write strobes, the burst-advance input and two burst-start strobes. One start strobe belongs to the processor and one to the cache controller. The output enable is the only input that acts asynchronously.

A burst begins when either start strobe loads a base address. On the cycles that follow, the low two address bits come from an internal two-bit counter, combined with the loaded base in interleaved order. The advance input steps that counter or holds it to insert a wait state. The processor strobe takes priority and always starts a read, but it is qualified by chip enable. The controller strobe starts a read or a write, and it deselects the device when chip enable is high.

The tri-state output is modelled as a data bus plus a valid flag. Read data for the address captured at a clock edge appears before the next edge, with no extra pipeline stage. A write is committed to the array at the clock edge that ends its cycle.

Top module: `burst_sram`

## Requirements
- R1: After reset the device is deselected: `rd_valid_o` is 0 and `rd_data_o` is 0 until a start strobe loads an address with chip enable low.
- R2: If `proc_start_n_i` and `chip_en_n_i` are both 0 at an edge, the external address is loaded as a new base with burst count 0. The cycle is a read even when `ctl_start_n_i` or either write strobe is 0, and nothing is written.
- R3: If `chip_en_n_i` and `ctl_start_n_i` are both 1, a 0 on `proc_start_n_i` is ignored: the address is not loaded and the device goes on as in a continue cycle.
- R4: If `ctl_start_n_i` is 0 and R2 does not apply, with chip enable 0, the address is loaded as a new base with count 0. The cycle is a write if either write strobe is 0, and a read otherwise.
- R5: A load through `ctl_start_n_i` with `chip_en_n_i` = 1 deselects the device. It stays deselected through later cycles in which both start strobes are 1. Chip enable has no effect on those non-loading cycles.
- R6: On a cycle with both start strobes at 1 while the device is selected, `adv_n_i` = 0 steps the burst count by one before the access. `adv_n_i` = 1 repeats the access at the current address (wait state). The cycle is a write if either write strobe is 0.
- R7: The access address keeps the upper base bits. Its two low bits equal the base's two low bits XOR the burst count. The count wraps from 3 to 0, so the fifth access of an advancing burst returns to the base address.
- R8: `wr_lo_n_i` = 0 writes data bits 8:0 and `wr_hi_n_i` = 0 writes bits 17:9. The lane whose strobe is 1 keeps its old content.
- R9: A processor-started write takes two cycles. First the processor strobe loads the address as a read. Then, with both start strobes 1 and `adv_n_i` = 1, a 0 on a write strobe writes the data to that same address.
- R10: `rd_valid_o` is 1 only on a selected read cycle with `out_en_n_i` = 0. Otherwise it is 0 and `rd_data_o` is 0: while output enable is high, on write cycles and when deselected. Output enable is ignored on write cycles.
- R11: Data written at one cycle is returned by a read of that address in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the burst state |
| addr_i | input | ADDR_W | External word address |
| wr_data_i | input | 18 | Write data |
| chip_en_n_i | input | 1 | Chip enable, active low, sampled on loads only |
| proc_start_n_i | input | 1 | Processor burst-start strobe, active low |
| ctl_start_n_i | input | 1 | Controller burst-start strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| wr_lo_n_i | input | 1 | Lower lane write strobe (bits 8:0), active low |
| wr_hi_n_i | input | 1 | Upper lane write strobe (bits 17:9), active low |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| rd_data_o | output | 18 | Read data, 0 when not valid |
| rd_valid_o | output | 1 | Read data drives the bus |

## Verification
Some relations can be checked on every cycle from the ports alone, and the assertions cover these. A processor load with chip enable low is followed by a driven read unless output is disabled. A controller deselect, and a controller write, are each followed by an undriven bus. A wait state during a read leaves the read data unchanged. The bench's scenarios are needed for everything that depends on what the array holds. That covers the interleaved order and wrap across all sixteen start addresses of a small configuration, single-lane writes preserving the other lane, the two-cycle processor write, a burst write, and the ignored processor strobe continuing the old burst.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
    localparam int LANE_W  = 9;
    localparam int LANES   = 2;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    typedef struct packed {
        acc_e               acc;
        logic [BURST_W-1:0] cnt;
        logic [LANES-1:0]   lane_we;
        logic [DATA_W-1:0]  wdata;
    } ctl_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic                chip_en_n_i,
    input  logic                proc_start_n_i,
    input  logic                ctl_start_n_i,
    input  logic                adv_n_i,
    input  logic [LANES-1:0]    lane_we_n_i,
    output acc_e                acc_o,
    output logic [ADDR_W-1:0]   base_o,
    output logic [BURST_W-1:0]  cnt_o,
    output logic [LANES-1:0]    lane_we_o,
    output logic [DATA_W-1:0]   wdata_o
);
    ctl_t              ctl_d, ctl_q;
    logic [ADDR_W-1:0] base_d, base_q;
    logic              proc_load, ctl_load, any_we;

    assign proc_load = !proc_start_n_i && !chip_en_n_i;
    assign ctl_load  = !ctl_start_n_i && !proc_load;
    assign any_we    = !(&lane_we_n_i);

    always_comb begin
        ctl_d       = ctl_q;
        base_d      = base_q;
        ctl_d.wdata = wr_data_i;
        if (proc_load) begin
            base_d        = addr_i;
            ctl_d.cnt     = '0;
            ctl_d.acc     = ACC_READ;
            ctl_d.lane_we = '0;
        end else if (ctl_load) begin
            if (chip_en_n_i) begin
                ctl_d.acc     = ACC_IDLE;
                ctl_d.lane_we = '0;
            end else begin
                base_d        = addr_i;
                ctl_d.cnt     = '0;
                ctl_d.acc     = any_we ? ACC_WRITE : ACC_READ;
                ctl_d.lane_we = ~lane_we_n_i;
            end
        end else if (ctl_q.acc != ACC_IDLE) begin
            if (!adv_n_i) begin
                ctl_d.cnt = BURST_W'(ctl_q.cnt + 1'b1);
            end
            ctl_d.acc     = any_we ? ACC_WRITE : ACC_READ;
            ctl_d.lane_we = ~lane_we_n_i;
        end else begin
            ctl_d.lane_we = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '{acc: ACC_IDLE, cnt: '0, lane_we: '0, wdata: '0};
            base_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            base_q <= base_d;
        end
    end

    assign acc_o     = ctl_q.acc;
    assign base_o    = base_q;
    assign cnt_o     = ctl_q.cnt;
    assign lane_we_o = (ctl_q.acc == ACC_WRITE) ? ctl_q.lane_we : '0;
    assign wdata_o   = ctl_q.wdata;
endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [BURST_W-1:0] cnt_i,
    output logic [ADDR_W-1:0]  acc_addr_o
);
    generate
        if (ADDR_W > BURST_W) begin : g_split
            assign acc_addr_o = {base_i[ADDR_W-1:BURST_W], base_i[BURST_W-1:0] ^ cnt_i};
        end else begin : g_small
            assign acc_addr_o = base_i ^ cnt_i[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic               clk,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [LANES-1:0]   lane_we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we_i[g]) begin
                mem_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem_q[addr_i];
    end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [17:0]       wr_data_i,
    input  logic              chip_en_n_i,
    input  logic              proc_start_n_i,
    input  logic              ctl_start_n_i,
    input  logic              adv_n_i,
    input  logic              wr_lo_n_i,
    input  logic              wr_hi_n_i,
    input  logic              out_en_n_i,
    output logic [17:0]       rd_data_o,
    output logic              rd_valid_o
);
    acc_e               acc;
    logic [ADDR_W-1:0]  base;
    logic [ADDR_W-1:0]  acc_addr;
    logic [BURST_W-1:0] cnt;
    logic [LANES-1:0]   lane_we;
    logic [DATA_W-1:0]  wdata;
    logic [DATA_W-1:0]  rdata;
    logic               drive;

    burst_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .addr_i         (addr_i),
        .wr_data_i      (wr_data_i),
        .chip_en_n_i    (chip_en_n_i),
        .proc_start_n_i (proc_start_n_i),
        .ctl_start_n_i  (ctl_start_n_i),
        .adv_n_i        (adv_n_i),
        .lane_we_n_i    ({wr_hi_n_i, wr_lo_n_i}),
        .acc_o          (acc),
        .base_o         (base),
        .cnt_o          (cnt),
        .lane_we_o      (lane_we),
        .wdata_o        (wdata)
    );

    burst_sram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .base_i     (base),
        .cnt_i      (cnt),
        .acc_addr_o (acc_addr)
    );

    burst_sram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .addr_i    (acc_addr),
        .lane_we_i (lane_we),
        .wdata_i   (wdata),
        .rdata_o   (rdata)
    );

    assign drive      = (acc == ACC_READ) && !out_en_n_i;
    assign rd_valid_o = drive;
    assign rd_data_o  = drive ? rdata : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int ADDR_W = 10
) (
    input logic        clk,
    input logic        rst_n,
    input logic        chip_en_n_i,
    input logic        proc_start_n_i,
    input logic        ctl_start_n_i,
    input logic        adv_n_i,
    input logic        wr_lo_n_i,
    input logic        wr_hi_n_i,
    input logic        out_en_n_i,
    input logic [17:0] rd_data_o,
    input logic        rd_valid_o
);
    // R2: processor load with chip enable low yields a driven read
    assert_proc_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_start_n_i && !chip_en_n_i) |=> (out_en_n_i || rd_valid_o));

    // R5: controller load with chip enable high deselects
    assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_start_n_i && chip_en_n_i) |=> !rd_valid_o);

    // R4 / R10: controller write cycle never drives the bus
    assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_start_n_i && !ctl_start_n_i && !chip_en_n_i && !(wr_lo_n_i && wr_hi_n_i))
        |=> !rd_valid_o);

    // R6: wait state during a read repeats the same data
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_start_n_i && ctl_start_n_i && adv_n_i && wr_lo_n_i && wr_hi_n_i && rd_valid_o)
        |=> (out_en_n_i || (rd_valid_o && $stable(rd_data_o))));
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .chip_en_n_i    (chip_en_n_i),
    .proc_start_n_i (proc_start_n_i),
    .ctl_start_n_i  (ctl_start_n_i),
    .adv_n_i        (adv_n_i),
    .wr_lo_n_i      (wr_lo_n_i),
    .wr_hi_n_i      (wr_hi_n_i),
    .out_en_n_i     (out_en_n_i),
    .rd_data_o      (rd_data_o),
    .rd_valid_o     (rd_valid_o)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [17:0]   din = '0;
    logic          ce_n = 1'b1, psn = 1'b1, csn = 1'b1, adv_n = 1'b1;
    logic          wlo_n = 1'b1, whi_n = 1'b1, oe_n = 1'b0;
    logic [17:0]   dout;
    logic          vld;
    logic [17:0]   shadow [DEPTH];
    int            checks = 0, errors = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) i_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_data_i(din),
        .chip_en_n_i(ce_n), .proc_start_n_i(psn), .ctl_start_n_i(csn),
        .adv_n_i(adv_n), .wr_lo_n_i(wlo_n), .wr_hi_n_i(whi_n),
        .out_en_n_i(oe_n), .rd_data_o(dout), .rd_valid_o(vld)
    );

    task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        psn = 1'b1; csn = 1'b1; adv_n = 1'b1; wlo_n = 1'b1; whi_n = 1'b1; ce_n = 1'b0;
    endtask

    function automatic logic [17:0] pat(input int a, input int salt);
        return 18'(a * 11093 + salt * 4099 + 777);
    endfunction

    function automatic int baddr(input int s, input int k);
        return (s & ~3) | ((s & 3) ^ (k & 3));
    endfunction

    task automatic proc_read(input int a);
        idle(); psn = 1'b0; addr = AW'(a); tick(); idle();
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1: deselected out of reset
        chk("R1 valid", 18'(vld), 18'd0);
        chk("R1 data", dout, 18'd0);

        // R4: fill by controller writes, bus quiet on writes
        for (int a = 0; a < DEPTH; a++) begin
            idle(); csn = 1'b0; addr = AW'(a); wlo_n = 1'b0; whi_n = 1'b0; din = pat(a, 1);
            tick();
            shadow[a] = pat(a, 1);
            chk("R4 write quiet", 18'(vld), 18'd0);
        end
        idle(); tick();

        // R7 / R6 / R11: every start address, four advances including wrap
        for (int s = 0; s < DEPTH; s++) begin
            proc_read(s);
            chk("R11 first read", dout, shadow[s]);
            for (int k = 1; k <= 4; k++) begin
                adv_n = 1'b0; tick();
                chk("R7 interleave", dout, shadow[baddr(s, k)]);
            end
            adv_n = 1'b1; tick();
            chk("R6 wait state", dout, shadow[s]);
        end

        // R2: processor load with controller strobe and write strobes low still reads
        idle(); psn = 1'b0; csn = 1'b0; wlo_n = 1'b0; whi_n = 1'b0; din = 18'h3ffff; addr = 4'd3;
        tick();
        chk("R2 read", dout, shadow[3]);
        idle(); tick();
        chk("R2 no write", dout, shadow[3]);

        // R4: controller read start
        idle(); csn = 1'b0; addr = 4'd7; tick();
        chk("R4 read start", dout, shadow[7]);
        chk("R4 read valid", 18'(vld), 18'd1);

        // R10: output enable high hides data, low restores it
        oe_n = 1'b1; #1;
        chk("R10 oe valid", 18'(vld), 18'd0);
        chk("R10 oe data", dout, 18'd0);
        oe_n = 1'b0; #1;
        chk("R10 oe restore", dout, shadow[7]);

        // R8: lower lane only
        idle(); csn = 1'b0; addr = 4'd6; wlo_n = 1'b0; din = pat(6, 9); oe_n = 1'b1;
        tick();
        chk("R10 write quiet oe ignored", 18'(vld), 18'd0);
        oe_n = 1'b0;
        shadow[6][8:0] = din[8:0];
        idle(); tick();
        chk("R8 lower lane", dout, shadow[6]);
        // R8: upper lane only
        idle(); csn = 1'b0; addr = 4'd13; whi_n = 1'b0; din = pat(13, 5);
        tick();
        shadow[13][17:9] = din[17:9];
        idle(); tick();
        chk("R8 upper lane", dout, shadow[13]);

        // R9: two-cycle processor write
        proc_read(9);
        chk("R9 first cycle read", dout, shadow[9]);
        wlo_n = 1'b0; whi_n = 1'b0; din = pat(9, 7);
        tick();
        chk("R9 second cycle quiet", 18'(vld), 18'd0);
        shadow[9] = din;
        idle(); tick();
        chk("R9 written", dout, shadow[9]);

        // R6 / R7: burst write from base 10
        idle(); csn = 1'b0; addr = 4'd10; wlo_n = 1'b0; whi_n = 1'b0; din = pat(10, 3);
        tick();
        shadow[10] = din;
        for (int k = 1; k < 4; k++) begin
            idle(); adv_n = 1'b0; wlo_n = 1'b0; whi_n = 1'b0; din = pat(baddr(10, k), 3);
            tick();
            shadow[baddr(10, k)] = din;
            chk("R6 burst write quiet", 18'(vld), 18'd0);
        end
        idle(); tick();
        for (int a = 8; a < 12; a++) begin
            proc_read(a);
            chk("R6 burst write readback", dout, shadow[a]);
        end

        // R5: chip enable ignored on continue cycles
        proc_read(4);
        ce_n = 1'b1; adv_n = 1'b0; tick();
        chk("R5 ce ignored", dout, shadow[baddr(4, 1)]);

        // R3: processor strobe ignored when chip enable and controller strobe high
        idle(); psn = 1'b0; ce_n = 1'b1; adv_n = 1'b0; addr = 4'd12; tick();
        chk("R3 ignored", dout, shadow[baddr(4, 2)]);

        // R5: controller deselect, persists
        idle(); csn = 1'b0; ce_n = 1'b1; addr = 4'd5; tick();
        chk("R5 deselect", 18'(vld), 18'd0);
        idle(); adv_n = 1'b0; tick();
        chk("R5 stays deselected", 18'(vld), 18'd0);
        chk("R5 data zero", dout, 18'd0);
        idle(); psn = 1'b0; ce_n = 1'b1; tick();
        chk("R3 ignored while deselected", 18'(vld), 18'd0);

        // R2: processor strobe with chip enable low while deselected
        proc_read(5);
        chk("R2 reselect", dout, shadow[5]);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule